// File: doc/BRIEF.md
# Power-Fail Supervisor Sequencer

This block carries a processor core through a loss of supply and back again. An analog monitor outside the block provides three comparator flags. Each flag reads 1 while the supply sits below its own threshold. The warning threshold is the highest, the minimum operating threshold is in the middle, and the battery switchover threshold is the lowest. The block filters these flags and from them derives a sequence of responses. The first is a maskable early-warning interrupt, during which the core keeps running. The second is a power-fail reset, which blocks all memory and write strobes. The third is an indication that the chip now runs from its backup cell.

When the supply climbs back above the minimum operating threshold, the core stays in reset for a fixed number of clocks. The same delay applies after the block's own reset is released. Two more pins can also hold the core in reset. The first is an active-high external reset input. The second is a shared open-drain reset line. The block pulls that line low while it is in power-fail reset, and any other device pulling it low forces this core into reset as well. Wiring the line between several chips in this way lets them leave reset together.

Top module: `pwr_fail_seq`

## Requirements
- R1: After `rst_n` is released, the block is in its start-up delay: `core_rst_o`, `por_busy_o`, `mem_en_force_o` and `rsync_pull_o` are 1, `pfi_req_o` is 0 and `batt_mode_n_o` is 1.
- R2: Each comparator flag passes through a 2-flop synchronizer. A change is accepted only after the synchronized value has differed from the accepted value on 4 consecutive clock edges. A warning flag driven high just after a clock edge raises `pfi_req_o` after the 8th following edge. A pulse lasting 3 clocks has no effect.
- R3: While the supply is below the warning level only, and `pfi_en_i` is 1, `pfi_req_o` rises and `pfi_vector_o` reads 16'h002B. `core_rst_o` and `mem_en_force_o` stay 0.
- R4: Once raised, `pfi_req_o` stays 1 until `pfi_ack_i` is seen at 1 or power-fail reset begins. No new request is raised until the warning flag has been accepted back at 0.
- R5: While the supply is below the minimum operating level, `core_rst_o`, `mem_en_force_o` and `rsync_pull_o` are 1 and a pending `pfi_req_o` is cleared.
- R6: While the supply is below the battery switchover level, `batt_mode_n_o` is 0. It returns to 1 once that flag is accepted back at 0.
- R7: When the supply recovers above the minimum operating level, `por_busy_o` is 1 for exactly POR_CYCLES (default 21504) clocks. `core_rst_o` and `mem_en_force_o` stay 1 throughout, and all three then fall.
- R8: `ext_rst_i` at 1 drives `core_rst_o` to 1 after a 2-flop synchronizer, for as long as it is held. It neither forces `mem_en_force_o` nor clears a pending request.
- R9: A low on `rsync_pin_i` caused by another device drives `core_rst_o` to 1 and leaves `mem_en_force_o` at 0.
- R10: A lower level takes precedence over any higher level. A battery flag alone is treated as a supply below all three levels: battery indication, power-fail reset and no interrupt.
- R11: With `pfi_en_i` at 0, no request is raised. Setting it to 1 while the supply is still below the warning level, with the request armed, raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lvl_warn_i | input | 1 | 1 while the supply is below the warning level |
| lvl_min_i | input | 1 | 1 while the supply is below the minimum operating level |
| lvl_batt_i | input | 1 | 1 while the supply is below the battery switchover level |
| ext_rst_i | input | 1 | External reset pin, active high |
| rsync_pin_i | input | 1 | Level sensed on the shared open-drain reset line (0 = reset) |
| rsync_pull_o | output | 1 | 1 pulls the shared reset line low |
| pfi_en_i | input | 1 | Warning interrupt enable |
| pfi_ack_i | input | 1 | Warning interrupt acknowledge |
| pfi_req_o | output | 1 | Warning interrupt request |
| pfi_vector_o | output | 16 | Warning interrupt vector address |
| core_rst_o | output | 1 | Reset to the core |
| mem_en_force_o | output | 1 | 1 forces every decoded memory enable and the write strobe inactive |
| batt_mode_n_o | output | 1 | 0 while running from the backup cell |
| por_busy_o | output | 1 | 1 during the recovery delay |

## Verification
The sharpest collision happens when the supply falls straight from above the warning level to below the minimum operating level. The warning filter and the minimum-level filter then accept their new values on the same clock edge. The bench provokes this by raising both comparator flags in the same cycle while the interrupt is armed and enabled. It judges the result by watching every cycle of the transition: `pfi_req_o` must never pulse, and `core_rst_o` must be high. A second collision comes from an acknowledge or an external reset arriving while a request is pending. The table covers it by checking that an external reset leaves the request pending and that an acknowledge clears it.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int NUM_LVL  = 3;
  localparam int LVL_WARN = 0;
  localparam int LVL_MIN  = 1;
  localparam int LVL_BATT = 2;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_WARN  = 3'd1,
    ST_PFRST = 3'd2,
    ST_BATT  = 3'd3,
    ST_POR   = 3'd4
  } pfs_state_e;
endpackage

// File: rtl/pfs_rst_sync.sv
module pfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pfs_lvl_filter.sv
module pfs_lvl_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int STABLE_CNT  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic lvl_o
);
  logic synced;

  pfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_i),
    .q_o  (synced)
  );

  generate
    if (STABLE_CNT > 1) begin : g_debounce
      localparam int CW = $clog2(STABLE_CNT);
      localparam logic [CW-1:0] CNT_LAST = CW'(STABLE_CNT - 1);

      logic [CW-1:0] cnt_q, cnt_d;
      logic          lvl_q, lvl_d;
      logic          upd_en;

      always_comb begin
        cnt_d = cnt_q;
        lvl_d = lvl_q;
        if (synced == lvl_q) begin
          cnt_d = '0;
        end else if (cnt_q == CNT_LAST) begin
          cnt_d = '0;
          lvl_d = synced;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      assign upd_en = (synced != lvl_q) || (cnt_q != '0);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
          lvl_q <= 1'b0;
        end else if (upd_en) begin
          cnt_q <= cnt_d;
          lvl_q <= lvl_d;
        end
      end

      assign lvl_o = lvl_q;
    end else begin : g_direct
      assign lvl_o = synced;
    end
  endgenerate
endmodule

// File: rtl/pfs_por_timer.sv
module pfs_por_timer #(
  parameter int POR_CYCLES = 21504
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = (POR_CYCLES > 1) ? $clog2(POR_CYCLES) : 1;
  localparam logic [CW-1:0] START = CW'(POR_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign done_o = (cnt_q == '0);
  assign cnt_en = load_i || (run_i && !done_o);

  always_comb begin
    if (load_i) cnt_d = START;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= START;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pfs_warn_irq.sv
module pfs_warn_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic warn_i,
  input  logic rearm_i,
  input  logic clr_i,
  input  logic en_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q, req_d;
  logic armed_q, armed_d;

  always_comb begin
    req_d   = req_q;
    armed_d = armed_q;
    if (clr_i) begin
      req_d   = 1'b0;
      armed_d = 1'b0;
    end else begin
      if (req_q && ack_i) req_d = 1'b0;
      if (warn_i && armed_q && en_i) begin
        req_d   = 1'b1;
        armed_d = 1'b0;
      end else if (rearm_i) begin
        armed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      armed_q <= armed_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/pwr_fail_seq.sv
module pwr_fail_seq #(
  parameter int          SYNC_STAGES = 2,
  parameter int          STABLE_CNT  = 4,
  parameter int          POR_CYCLES  = 21504,
  parameter int          VEC_W       = 16,
  parameter logic [15:0] PFI_VECTOR  = 16'h002B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lvl_warn_i,
  input  logic             lvl_min_i,
  input  logic             lvl_batt_i,
  input  logic             ext_rst_i,
  input  logic             rsync_pin_i,
  output logic             rsync_pull_o,
  input  logic             pfi_en_i,
  input  logic             pfi_ack_i,
  output logic             pfi_req_o,
  output logic [VEC_W-1:0] pfi_vector_o,
  output logic             core_rst_o,
  output logic             mem_en_force_o,
  output logic             batt_mode_n_o,
  output logic             por_busy_o
);
  import pfs_pkg::*;

  logic               rst_n_s;
  logic [NUM_LVL-1:0] lvl_raw, lvl_acc;
  logic               ext_rst_s, rsync_s;
  logic               below_batt, below_min, below_warn;
  logic               hold, pfr, por_done;
  pfs_state_e         state_q, state_d;

  pfs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_s)
  );

  assign lvl_raw[LVL_WARN] = lvl_warn_i;
  assign lvl_raw[LVL_MIN]  = lvl_min_i;
  assign lvl_raw[LVL_BATT] = lvl_batt_i;

  generate
    for (genvar gi = 0; gi < NUM_LVL; gi++) begin : g_lvl
      pfs_lvl_filter #(
        .SYNC_STAGES(SYNC_STAGES),
        .STABLE_CNT (STABLE_CNT)
      ) u_filt (
        .clk  (clk),
        .rst_n(rst_n_s),
        .raw_i(lvl_raw[gi]),
        .lvl_o(lvl_acc[gi])
      );
    end
  endgenerate

  pfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d_i  (ext_rst_i),
    .q_o  (ext_rst_s)
  );

  pfs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rsync_sync (
    .clk  (clk),
    .rst_n(rst_n_s),
    .d_i  (rsync_pin_i),
    .q_o  (rsync_s)
  );

  // lower thresholds imply the higher ones
  assign below_batt = lvl_acc[LVL_BATT];
  assign below_min  = lvl_acc[LVL_MIN] | below_batt;
  assign below_warn = lvl_acc[LVL_WARN] | below_min;

  assign hold = (state_q == ST_PFRST) || (state_q == ST_BATT);
  assign pfr  = hold || (state_q == ST_POR);

  always_comb begin
    if (below_batt) begin
      state_d = ST_BATT;
    end else if (below_min) begin
      state_d = ST_PFRST;
    end else if (hold) begin
      state_d = ST_POR;
    end else if ((state_q == ST_POR) && !por_done) begin
      state_d = ST_POR;
    end else if (below_warn) begin
      state_d = ST_WARN;
    end else begin
      state_d = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) state_q <= ST_POR;
    else          state_q <= state_d;
  end

  pfs_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk   (clk),
    .rst_n (rst_n_s),
    .load_i(hold),
    .run_i (state_q == ST_POR),
    .done_o(por_done)
  );

  pfs_warn_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .warn_i (state_q == ST_WARN),
    .rearm_i(state_q == ST_RUN),
    .clr_i  (pfr),
    .en_i   (pfi_en_i),
    .ack_i  (pfi_ack_i),
    .req_o  (pfi_req_o)
  );

  assign pfi_vector_o   = VEC_W'(PFI_VECTOR);
  assign core_rst_o     = pfr || ext_rst_s || !rsync_s;
  assign mem_en_force_o = pfr;
  assign rsync_pull_o   = pfr;
  assign batt_mode_n_o  = (state_q != ST_BATT);
  assign por_busy_o     = (state_q == ST_POR);
endmodule

// File: rtl/pwr_fail_seq_chk.sv
module pwr_fail_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic pfi_en_i,
  input logic pfi_ack_i,
  input logic pfi_req_o,
  input logic core_rst_o,
  input logic mem_en_force_o,
  input logic batt_mode_n_o,
  input logic por_busy_o
);
  assert_por_holds_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    por_busy_o |-> (core_rst_o && mem_en_force_o));

  assert_force_implies_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en_force_o |-> core_rst_o);

  assert_batt_forces_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !batt_mode_n_o |-> mem_en_force_o);

  assert_req_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pfi_req_o && !pfi_ack_i && !mem_en_force_o) |=> pfi_req_o);

  assert_req_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pfi_req_o) |-> $past(pfi_en_i));

  assert_no_req_in_pfr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en_force_o && $past(mem_en_force_o)) |-> !pfi_req_o);
endmodule

bind pwr_fail_seq pwr_fail_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pfi_en_i      (pfi_en_i),
  .pfi_ack_i     (pfi_ack_i),
  .pfi_req_o     (pfi_req_o),
  .core_rst_o    (core_rst_o),
  .mem_en_force_o(mem_en_force_o),
  .batt_mode_n_o (batt_mode_n_o),
  .por_busy_o    (por_busy_o)
);

// File: tb/pwr_fail_seq_tb.sv
module pwr_fail_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int POR_N      = 21504;
  localparam int WDOG_LIMIT = 190000;
  localparam int NVEC       = 11;

  // stimulus {warn,min,batt,ext,other_pull,en,ack} , expected {req,rst,force,batt_n}
  localparam logic [10:0] VECS [NVEC] = '{
    11'b0000010_0001,  // R3 baseline, all above
    11'b1000010_1001,  // R3 warning raises request
    11'b1000011_0001,  // R4 ack clears
    11'b1000010_0001,  // R4 no re-raise while still below
    11'b0000010_0001,  // R4 back above, rearm
    11'b1000000_0001,  // R11 masked
    11'b1000010_1001,  // R11 enabled late
    11'b1001010_1101,  // R8 external reset, request kept
    11'b1000011_0001,  // R8 release, ack
    11'b1000110_0101,  // R9 other device pulls line low
    11'b0000010_0001   // R9 release
  };

  logic clk, rst_n;
  logic lvl_warn, lvl_min, lvl_batt, ext_rst, other_pull, pfi_en, pfi_ack;
  logic rsync_pull, pfi_req, core_rst, mem_force, batt_n, por_busy;
  logic [15:0] pfi_vec;
  logic rsync_pin;

  int n_chk, n_fail;
  bit done;

  assign rsync_pin = ~(rsync_pull | other_pull);

  pwr_fail_seq u_dut (
    .clk(clk), .rst_n(rst_n),
    .lvl_warn_i(lvl_warn), .lvl_min_i(lvl_min), .lvl_batt_i(lvl_batt),
    .ext_rst_i(ext_rst), .rsync_pin_i(rsync_pin), .rsync_pull_o(rsync_pull),
    .pfi_en_i(pfi_en), .pfi_ack_i(pfi_ack), .pfi_req_o(pfi_req),
    .pfi_vector_o(pfi_vec), .core_rst_o(core_rst), .mem_en_force_o(mem_force),
    .batt_mode_n_o(batt_n), .por_busy_o(por_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // waits for the recovery delay to start and returns its length in cycles
  task automatic measure_por(output int len, output int rst_gaps);
    len = 0; rst_gaps = 0;
    for (int i = 0; i < 60 && !por_busy; i++) @(negedge clk);
    while (por_busy && len < POR_N + 100) begin
      len++;
      if (!core_rst || !mem_force) rst_gaps++;
      @(negedge clk);
    end
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WDOG_LIMIT) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG_LIMIT);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int len, gaps;
    bit saw_req;
    n_chk = 0; n_fail = 0; done = 0;
    rst_n = 1'b0;
    lvl_warn = 0; lvl_min = 0; lvl_batt = 0; ext_rst = 0; other_pull = 0;
    pfi_en = 1; pfi_ack = 0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);
    // R1 reset state
    chk("R1 core_rst", 32'(core_rst), 1);
    chk("R1 por_busy", 32'(por_busy), 1);
    chk("R1 mem_force", 32'(mem_force), 1);
    chk("R1 rsync_pull", 32'(rsync_pull), 1);
    chk("R1 pfi_req", 32'(pfi_req), 0);
    chk("R1 batt_n", 32'(batt_n), 1);
    for (int i = 0; i < POR_N + 100 && por_busy; i++) @(negedge clk);
    wait_n(2);
    chk("R1 start-up delay ends", 32'(core_rst), 0);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      {lvl_warn, lvl_min, lvl_batt, ext_rst, other_pull, pfi_en, pfi_ack} = VECS[v][10:4];
      wait_n(12);
      chk($sformatf("R3/R4/R8/R9/R11 vec%0d req", v), 32'(pfi_req), 32'(VECS[v][3]));
      chk($sformatf("R3/R8/R9 vec%0d rst", v), 32'(core_rst), 32'(VECS[v][2]));
      chk($sformatf("R3/R8/R9 vec%0d force", v), 32'(mem_force), 32'(VECS[v][1]));
      chk($sformatf("R6 vec%0d batt_n", v), 32'(batt_n), 32'(VECS[v][0]));
    end
    chk("R3 vector", 32'(pfi_vec), 32'h002B);

    // R2 exact acceptance latency
    lvl_warn = 1;
    wait_n(7);
    chk("R2 req before 8th edge", 32'(pfi_req), 0);
    wait_n(1);
    chk("R2 req after 8th edge", 32'(pfi_req), 1);
    pfi_ack = 1; lvl_warn = 0;
    wait_n(20);
    pfi_ack = 0;
    // R2 three-cycle glitch is ignored
    lvl_warn = 1;
    wait_n(3);
    lvl_warn = 0;
    saw_req = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pfi_req) saw_req = 1;
    end
    chk("R2 glitch ignored", 32'(saw_req), 0);

    // R5 / R6 / R7 full descent and recovery
    lvl_warn = 1;
    wait_n(12);
    chk("R3 pending before descent", 32'(pfi_req), 1);
    lvl_min = 1;
    wait_n(12);
    chk("R5 rst", 32'(core_rst), 1);
    chk("R5 force", 32'(mem_force), 1);
    chk("R5 pull", 32'(rsync_pull), 1);
    chk("R5 req cleared", 32'(pfi_req), 0);
    chk("R5 batt_n still 1", 32'(batt_n), 1);
    lvl_batt = 1;
    wait_n(12);
    chk("R6 batt_n low", 32'(batt_n), 0);
    lvl_batt = 0;
    wait_n(12);
    chk("R6 batt_n back", 32'(batt_n), 1);
    chk("R6 still in reset", 32'(core_rst), 1);
    lvl_min = 0; lvl_warn = 0;
    measure_por(len, gaps);
    chk("R7 delay length", 32'(len), POR_N);
    chk("R7 reset held throughout", 32'(gaps), 0);
    wait_n(2);
    chk("R7 rst released", 32'(core_rst), 0);
    chk("R7 force released", 32'(mem_force), 0);

    // R10 battery flag alone
    lvl_batt = 1;
    saw_req = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (pfi_req) saw_req = 1;
    end
    chk("R10 batt_n", 32'(batt_n), 0);
    chk("R10 force", 32'(mem_force), 1);
    chk("R10 no request", 32'(saw_req), 0);
    lvl_batt = 0;
    measure_por(len, gaps);
    chk("R10 recovery length", 32'(len), POR_N);
    wait_n(4);

    // collision: warning and minimum accepted on the same edge
    lvl_warn = 1; lvl_min = 1;
    saw_req = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pfi_req) saw_req = 1;
    end
    chk("R10 collision no request", 32'(saw_req), 0);
    chk("R5 collision reset", 32'(core_rst), 1);
    lvl_warn = 0; lvl_min = 0;
    measure_por(len, gaps);
    chk("R7 collision recovery", 32'(len), POR_N);
    wait_n(2);
    chk("R7 final run", 32'(core_rst), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule